// File: doc/BRIEF.md
# Flash Unlock Command Sequencer

This block sits behind the host-side pins of a 16-bit NOR flash and turns host write cycles into decoded commands. Every command opens with the same two-write unlock prefix. The third write then chooses the path: a word program, identification entry or exit, or a second unlock pair that ends in a chip, block or page erase or a boot-lockout request. For each complete sequence the block raises `cmd_valid` for one clock. With that pulse it presents the command code, and, where the command carries them, the target address and data. Executing the commands and accessing the array are handled elsewhere.

The chip-enable, output-enable and write-enable strobes are asynchronous, so they first pass through synchronisers. A write counts only when enable is held low for at least `MIN_PULSE` clocks while chip enable is low and output enable is high. The address is taken when the write begins and the data when it ends. A write that does not fit the expected sequence drops the partial sequence, and so does any read cycle. The block tracks an identification-mode flag and, while that flag is set, returns the identification words on reads.

The command output is a plain pulse with no ready signal. `busy_i` is the only back-pressure: while it is high, the sequencer discards finished writes and keeps its state. Once `busy_i` falls, it waits for the unlock prefix again.

Top module: `flash_cmd_sequencer`

## Requirements
- R1: Address matches compare only `addr[14:0]`, so the unlock addresses are 0x5555 and 0x2AAA in those bits. Data matches compare only `wdata[7:0]`, and `wdata[15:8]` is ignored.
- R2: The writes 0xAA@0x5555, 0x55@0x2AAA, 0xA0@0x5555 and then any write give one pulse with `cmd_kind`=1 (program). The pulse carries the full address and all 16 data bits of the fourth write.
- R3: Unlock followed by 0x90@0x5555 pulses `cmd_kind`=6 and sets `id_mode`. Unlock followed by 0xF0@0x5555 pulses `cmd_kind`=7 and clears it.
- R4: In the idle state, a single write of 0xF0 to any address pulses `cmd_kind`=7 and clears `id_mode`.
- R5: The long form is unlock, 0x80@0x5555, unlock, then a sixth write. The sixth write decodes as follows: 0x10@0x5555 gives kind 2 (chip erase), 0x30 at any address gives kind 3 (block erase), 0x50 at any address gives kind 4 (page erase), and 0x40@0x5555 gives kind 5 (boot lockout). Kinds 3 and 4 report the sixth write's address. 0x10 at any other address gives no command.
- R6: A write that does not match the expected address or data drops the sequence without a pulse. The next write is treated as the start of a new sequence.
- R7: A read cycle (chip enable and output enable both low) in the middle of a sequence drops it without a pulse.
- R8: A write-enable low time shorter than `MIN_PULSE` clocks is ignored and leaves the sequence where it was. A write with output enable low produces no write.
- R9: The command address is the value at the start of the write-enable low time. The command data is the value at its end.
- R10: Writes that end while `busy_i` is high are discarded with no pulse and no change of state.
- R11: While `id_mode` is set, a read at address 0 gives `id_rd_valid`=1 with 0x00DA, and a read at address 1 gives the device code (default 0x003D). Reads at other addresses, and all reads outside identification mode, keep `id_rd_valid` at 0.
- R12: After reset, `cmd_valid`, `id_mode` and `id_rd_valid` are 0. `cmd_valid` is never high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| addr | input | 18 | Word address, held stable around strobe edges |
| wdata | input | 16 | Write data from the host |
| busy_i | input | 1 | Executor busy; finished writes are discarded |
| cmd_valid | output | 1 | One-clock pulse per decoded command |
| cmd_kind | output | 3 | Command code (1..7, see R2 to R5) |
| cmd_addr | output | 18 | Address of the final write of the sequence |
| cmd_data | output | 16 | Data of the final write of the sequence |
| id_mode | output | 1 | Identification mode flag |
| id_rd_valid | output | 1 | A read is hitting an identification word |
| id_rd_data | output | 16 | Identification word for the current read address |

## Verification
The directed scenarios target the places where a sequencer most often goes wrong. An aliased unlock address with junk in the upper data byte tests R1; a decoder that compared too many bits would never unlock. A glitch in the middle of a sequence must be ignored without resetting the state, so a design that reset on short pulses would lose the identification entry that follows it. A read in the middle of a sequence, or a wrong third write, is followed by the tail of a program sequence: a design that failed to abort would issue a program command that should not exist. The address and data are changed while write enable is still low, which exposes a design that captures both on the same edge, and a full sequence sent while busy must leave both `id_mode` and the command count unchanged.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;
  typedef enum logic [2:0] {
    CMD_NONE        = 3'd0,
    CMD_PROG        = 3'd1,
    CMD_CHIP_ERASE  = 3'd2,
    CMD_BLOCK_ERASE = 3'd3,
    CMD_PAGE_ERASE  = 3'd4,
    CMD_BOOT_LOCK   = 3'd5,
    CMD_ID_ENTER    = 3'd6,
    CMD_ID_EXIT     = 3'd7
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERS3, S_ERS4, S_ERS5
  } seq_state_e;

  localparam int          KEY_ADDR_W = 15;
  localparam logic [14:0] KEY_ADDR_A = 15'h5555;
  localparam logic [14:0] KEY_ADDR_B = 15'h2AAA;

  localparam logic [7:0] OP_UNLOCK1 = 8'hAA;
  localparam logic [7:0] OP_UNLOCK2 = 8'h55;
  localparam logic [7:0] OP_PROG    = 8'hA0;
  localparam logic [7:0] OP_ID_IN   = 8'h90;
  localparam logic [7:0] OP_ID_OUT  = 8'hF0;
  localparam logic [7:0] OP_ERASE   = 8'h80;
  localparam logic [7:0] OP_CHIP    = 8'h10;
  localparam logic [7:0] OP_BLOCK   = 8'h30;
  localparam logic [7:0] OP_PAGE    = 8'h50;
  localparam logic [7:0] OP_LOCK    = 8'h40;
endpackage

// File: rtl/flash_bit_sync.sv
module flash_bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr <= {STAGES{RST_VAL}};
    end else begin
      sr[0] <= d;
      for (int i = 1; i < STAGES; i++) sr[i] <= sr[i-1];
    end
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/flash_wr_filter.sv
module flash_wr_filter #(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              rd_act,
  output logic              rd_evt
);
  localparam int CW = $clog2(MIN_PULSE + 1);
  localparam int NSTROBE = 3;

  logic [NSTROBE-1:0] strobe_raw, strobe_s;
  logic [CW-1:0]      cnt;
  logic               wr_act, rd_act_q;

  assign strobe_raw = {we_n, oe_n, ce_n};

  for (genvar g = 0; g < NSTROBE; g++) begin : g_sync
    flash_bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(strobe_raw[g]), .q(strobe_s[g])
    );
  end

  // write qualifies only with chip enabled, outputs disabled, write enable low
  assign wr_act = ~strobe_s[0] & strobe_s[1] & ~strobe_s[2];
  assign rd_act = ~strobe_s[0] & ~strobe_s[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
      if (wr_act) begin
        if (cnt == '0) wr_addr <= addr;   // address taken at the opening edge
        wr_data <= wdata;                 // data keeps the last value before the closing edge
        if (cnt != CW'(MIN_PULSE)) cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
      end
    end
  end

  assign wr_evt = ~wr_act & (cnt == CW'(MIN_PULSE));
  assign rd_evt = rd_act & ~rd_act_q;

  p_evt_after_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |-> $past(wr_act));
  p_no_write_on_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_act |-> !wr_act);
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
  import flash_seq_pkg::*;
#(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_evt,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_evt,
  input  logic              busy_i,
  output logic              cmd_valid,
  output cmd_kind_e         cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_mode
);
  seq_state_e state, nxt;
  cmd_kind_e  kind;
  logic       fire, at_a, at_b;
  logic [7:0] op;

  assign at_a = (wr_addr[KEY_ADDR_W-1:0] == KEY_ADDR_A);
  assign at_b = (wr_addr[KEY_ADDR_W-1:0] == KEY_ADDR_B);
  assign op   = wr_data[7:0];

  always_comb begin
    nxt  = state;
    fire = 1'b0;
    kind = CMD_NONE;
    if (rd_evt) begin
      nxt = S_IDLE;
    end else if (wr_evt && !busy_i) begin
      nxt = S_IDLE;
      case (state)
        S_IDLE: begin
          if (op == OP_ID_OUT) begin
            fire = 1'b1; kind = CMD_ID_EXIT;
          end else if (at_a && op == OP_UNLOCK1) begin
            nxt = S_UNL1;
          end
        end
        S_UNL1: if (at_b && op == OP_UNLOCK2) nxt = S_UNL2;
        S_UNL2: begin
          if (at_a) begin
            case (op)
              OP_PROG:   nxt = S_PROG;
              OP_ERASE:  nxt = S_ERS3;
              OP_ID_IN:  begin fire = 1'b1; kind = CMD_ID_ENTER; end
              OP_ID_OUT: begin fire = 1'b1; kind = CMD_ID_EXIT;  end
              default:   nxt = S_IDLE;
            endcase
          end
        end
        S_PROG: begin fire = 1'b1; kind = CMD_PROG; end
        S_ERS3: if (at_a && op == OP_UNLOCK1) nxt = S_ERS4;
        S_ERS4: if (at_b && op == OP_UNLOCK2) nxt = S_ERS5;
        S_ERS5: begin
          case (op)
            OP_CHIP:  if (at_a) begin fire = 1'b1; kind = CMD_CHIP_ERASE; end
            OP_LOCK:  if (at_a) begin fire = 1'b1; kind = CMD_BOOT_LOCK;  end
            OP_BLOCK: begin fire = 1'b1; kind = CMD_BLOCK_ERASE; end
            OP_PAGE:  begin fire = 1'b1; kind = CMD_PAGE_ERASE;  end
            default:  nxt = S_IDLE;
          endcase
        end
        default: nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cmd_valid <= 1'b0;
      cmd_kind  <= CMD_NONE;
      cmd_addr  <= '0;
      cmd_data  <= '0;
      id_mode   <= 1'b0;
    end else begin
      state     <= nxt;
      cmd_valid <= fire;
      if (fire) begin
        cmd_kind <= kind;
        cmd_addr <= wr_addr;
        cmd_data <= wr_data;
        if (kind == CMD_ID_ENTER) id_mode <= 1'b1;
        if (kind == CMD_ID_EXIT)  id_mode <= 1'b0;
      end
    end
  end

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid);
  p_busy_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !$past(busy_i));
  p_read_abort_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_evt && state != S_IDLE) |=> state == S_IDLE);
  p_id_enter_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == CMD_ID_ENTER) |-> id_mode);
  p_id_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_kind == CMD_ID_EXIT) |-> !id_mode);
endmodule

// File: rtl/flash_id_rom.sv
module flash_id_rom #(
  parameter int          ADDR_W   = 18,
  parameter int          DATA_W   = 16,
  parameter logic [15:0] MFR_CODE = 16'h00DA,
  parameter logic [15:0] DEV_CODE = 16'h003D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_mode,
  input  logic              rd_act,
  input  logic [ADDR_W-1:0] addr,
  output logic              id_rd_valid,
  output logic [DATA_W-1:0] id_rd_data
);
  localparam int NWORDS = 2;
  logic hit;

  assign hit = id_mode && rd_act && (addr < ADDR_W'(NWORDS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_rd_valid <= 1'b0;
      id_rd_data  <= '0;
    end else begin
      id_rd_valid <= hit;
      if (hit) id_rd_data <= addr[0] ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);
    end
  end

  p_id_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !id_mode |=> !id_rd_valid);
endmodule

// File: rtl/flash_cmd_sequencer.sv
module flash_cmd_sequencer
  import flash_seq_pkg::*;
#(
  parameter int          ADDR_W      = 18,
  parameter int          DATA_W      = 16,
  parameter int          SYNC_STAGES = 2,
  parameter int          MIN_PULSE   = 3,
  parameter logic [15:0] MFR_CODE    = 16'h00DA,
  parameter logic [15:0] DEV_CODE    = 16'h003D
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy_i,
  output logic              cmd_valid,
  output logic [2:0]        cmd_kind,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              id_mode,
  output logic              id_rd_valid,
  output logic [DATA_W-1:0] id_rd_data
);
  logic              wr_evt, rd_evt, rd_act;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  cmd_kind_e         kind_e;

  flash_wr_filter #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)
  ) u_filter (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(rd_act), .rd_evt(rd_evt)
  );

  flash_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_evt(rd_evt), .busy_i(busy_i),
    .cmd_valid(cmd_valid), .cmd_kind(kind_e), .cmd_addr(cmd_addr),
    .cmd_data(cmd_data), .id_mode(id_mode)
  );

  flash_id_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)
  ) u_id (
    .clk(clk), .rst_n(rst_n), .id_mode(id_mode), .rd_act(rd_act),
    .addr(addr), .id_rd_valid(id_rd_valid), .id_rd_data(id_rd_data)
  );

  assign cmd_kind = kind_e;
endmodule

// File: tb/flash_cmd_sequencer_tb.sv
module flash_cmd_sequencer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, busy_i = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        cmd_valid, id_mode, id_rd_valid;
  logic [2:0]  cmd_kind;
  logic [17:0] cmd_addr;
  logic [15:0] cmd_data, id_rd_data;

  int checks = 0, failures = 0;
  int n_cmd = 0;
  bit pulse_long = 1'b0, prev_valid = 1'b0, done = 1'b0;
  logic [2:0]  m_kind;
  logic [17:0] m_addr;
  logic [15:0] m_data;

  always #2 clk = ~clk;

  flash_cmd_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .busy_i(busy_i), .cmd_valid(cmd_valid),
    .cmd_kind(cmd_kind), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .id_mode(id_mode), .id_rd_valid(id_rd_valid), .id_rd_data(id_rd_data)
  );

  always @(negedge clk) begin
    if (cmd_valid) begin
      n_cmd++;
      m_kind = cmd_kind; m_addr = cmd_addr; m_data = cmd_data;
      if (prev_valid) pulse_long = 1'b1;
    end
    prev_valid = cmd_valid;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [17:0] a, input logic [15:0] d, input int width = 6);
    @(negedge clk); addr = a; wdata = d; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (width) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd(input logic [17:0] a, output logic v, output logic [15:0] d);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    repeat (6) @(negedge clk);
    v = id_rd_valid; d = id_rd_data;
    oe_n = 1'b1; ce_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic unl();
    wr(18'h05555, 16'h00AA);
    wr(18'h02AAA, 16'h0055);
  endtask

  task automatic erase6(input logic [17:0] a, input logic [7:0] op);
    unl(); wr(18'h05555, 16'h0080);
    unl(); wr(a, {8'h00, op});
  endtask

  task automatic t_reset();
    chk("R12 reset cmd_valid", cmd_valid, 0);
    chk("R12 reset id_mode", id_mode, 0);
    chk("R12 reset id_rd_valid", id_rd_valid, 0);
  endtask

  task automatic t_program();
    int n0 = n_cmd;
    wr(18'h3D555, 16'hC3AA);          // R1: aliased high bits, junk upper byte
    wr(18'h02AAA, 16'h7E55);
    wr(18'h05555, 16'h00A0);
    wr(18'h23456, 16'hBEEF);
    chk("R2 program count", n_cmd - n0, 1);
    chk("R2 program kind", m_kind, 1);
    chk("R2 program addr", m_addr, 18'h23456);
    chk("R2 program data", m_data, 16'hBEEF);
    chk("R1 alias unlock", n_cmd - n0, 1);
  endtask

  task automatic t_id();
    logic v; logic [15:0] d;
    unl(); wr(18'h05555, 16'h0090);
    chk("R3 enter kind", m_kind, 6);
    chk("R3 enter id_mode", id_mode, 1);
    rd(18'h00000, v, d);
    chk("R11 mfr valid", v, 1); chk("R11 mfr code", d, 16'h00DA);
    rd(18'h00001, v, d);
    chk("R11 dev valid", v, 1); chk("R11 dev code", d, 16'h003D);
    rd(18'h00005, v, d);
    chk("R11 other addr", v, 0);
    unl(); wr(18'h05555, 16'h00F0);
    chk("R3 exit kind", m_kind, 7);
    chk("R3 exit id_mode", id_mode, 0);
    rd(18'h00000, v, d);
    chk("R11 outside id", v, 0);
  endtask

  task automatic t_short_exit();
    unl(); wr(18'h05555, 16'h0090);
    chk("R4 pre id_mode", id_mode, 1);
    wr(18'h12345, 16'h00F0);
    chk("R4 short exit kind", m_kind, 7);
    chk("R4 short exit id_mode", id_mode, 0);
  endtask

  task automatic t_erase();
    int n0;
    erase6(18'h05555, 8'h10);
    chk("R5 chip kind", m_kind, 2);
    erase6(18'h28000, 8'h30);
    chk("R5 block kind", m_kind, 3); chk("R5 block addr", m_addr, 18'h28000);
    erase6(18'h01800, 8'h50);
    chk("R5 page kind", m_kind, 4); chk("R5 page addr", m_addr, 18'h01800);
    erase6(18'h05555, 8'h40);
    chk("R5 lock kind", m_kind, 5);
    n0 = n_cmd;
    erase6(18'h01234, 8'h10);
    chk("R5 chip wrong addr", n_cmd - n0, 0);
  endtask

  task automatic t_abort_write();
    int n0 = n_cmd;
    unl(); wr(18'h05555, 16'h0077);
    wr(18'h05555, 16'h00A0);
    wr(18'h00100, 16'h1234);
    chk("R6 no command after bad write", n_cmd - n0, 0);
    unl(); wr(18'h05555, 16'h00A0); wr(18'h00100, 16'h1234);
    chk("R6 recovers", n_cmd - n0, 1);
    chk("R6 recovered kind", m_kind, 1);
  endtask

  task automatic t_abort_read();
    logic v; logic [15:0] d;
    int n0 = n_cmd;
    unl(); rd(18'h00040, v, d);
    wr(18'h05555, 16'h00A0);
    wr(18'h00200, 16'h5A5A);
    chk("R7 read aborts", n_cmd - n0, 0);
  endtask

  task automatic t_glitch();
    unl();
    wr(18'h05555, 16'h0090, 1);
    chk("R8 glitch ignored", id_mode, 0);
    wr(18'h05555, 16'h0090);
    chk("R8 state kept after glitch", id_mode, 1);
    @(negedge clk); addr = 18'h00300; wdata = 16'h00F0; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (6) @(negedge clk);
    we_n = 1'b1; oe_n = 1'b1; ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R8 write with oe low blocked", id_mode, 1);
    wr(18'h00000, 16'h00F0);
    chk("R8 cleanup exit", id_mode, 0);
  endtask

  task automatic t_capture();
    unl(); wr(18'h05555, 16'h00A0);
    @(negedge clk); addr = 18'h0ABCD; wdata = 16'h1111; ce_n = 1'b0;
    @(negedge clk); we_n = 1'b0;
    repeat (5) @(negedge clk);
    addr = 18'h15432; wdata = 16'h2222;
    repeat (5) @(negedge clk);
    we_n = 1'b1;
    repeat (2) @(negedge clk);
    ce_n = 1'b1;
    repeat (8) @(negedge clk);
    chk("R9 addr at opening", m_addr, 18'h0ABCD);
    chk("R9 data at closing", m_data, 16'h2222);
  endtask

  task automatic t_busy();
    int n0 = n_cmd;
    busy_i = 1'b1;
    unl(); wr(18'h05555, 16'h0090);
    chk("R10 busy no command", n_cmd - n0, 0);
    chk("R10 busy id_mode", id_mode, 0);
    busy_i = 1'b0;
    unl(); wr(18'h05555, 16'h0090);
    chk("R10 resumes", id_mode, 1);
    wr(18'h00000, 16'h00F0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_program();
    t_id();
    t_short_exit();
    t_erase();
    t_abort_write();
    t_abort_read();
    t_glitch();
    t_capture();
    t_busy();
    chk("R12 single-cycle pulses", pulse_long, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule